// File: doc/BRIEF.md
# Pixel Output Delay Aligner with Run-On Flush

This block sits between the raw control and address outputs of an image resampling sequencer and the pins of the chip. Each output group (for example a target address, a write strobe bundle or an interpolator control word) passes through its own delay line. A 3-bit code sets the delay of each group anywhere from 0 to 7 clocks, so the external interpolator, image buffer and coefficient memory can be matched cycle for cycle. The source address and the coefficient address are not delayed: they always leave the block in the same cycle they arrive.

The block also decides when a group's output counts as live. A transform starts with a one-cycle `init` pulse and ends with a one-cycle `done` pulse from the sequencer. After `done` the block stays live for a programmed number of extra clocks, so the final resampled pixel is pushed through the delayed pipeline into target memory. If the next `init` arrives within that window, the live state never drops, and valid data leaves the pins on the first clock of the new transform whatever the delay settings. Outside the live window every delayed group reads as zero. There is no back-pressure: the sequencer side runs every clock, so there are no valid/ready handshakes and the control pins are plain.

Top module: `pix_out_aligner`

## Requirements
- R1: `src_addr_out` equals `src_addr_in` and `coef_addr_out` equals `coef_addr_in` in the same cycle, at all times including reset, with no delay and no gating.
- R2: Group g (input bits `grp_in[g*GW +: GW]`) leaves on `grp_out[g*GW +: GW]` exactly d cycles after it enters, where d is the active code of that group (0 to 7); code 0 means same-cycle passthrough. The groups are independent of one another.
- R3: The code of group g is taken from `dly_code[3g+2:3g]` only in a cycle where `init` is 1; a change of `dly_code` in any other cycle has no effect on any output until the next `init`.
- R4: The raw live state becomes 1 in the cycle after `init` and holds until and including the cycle of `done`; after `done` it stays 1 for exactly `runon_len` more cycles (the count is reloaded on each `done` and counts down once per clock to zero).
- R5: Each delayed group carries the live state through its own delay; when the delayed live bit is 0 the group's data and done outputs read 0. With `runon_len` = 0 a group's output goes to 0 one cycle after its delayed done.
- R6: An `init` that arrives while the run-on count is non-zero keeps the live state at 1 without a gap, so delayed outputs of both transforms appear back to back.
- R7: `pipe_act` is 1 exactly when the raw live state is 1 or any group's delayed live bit is 1.
- R8: While `rst_n` is 0 all delayed outputs and `pipe_act` are 0, and after reset all active codes are 0 and the live state is 0.
- R9: `grp_done_out[g]` is the raw `done` delayed by group g's active code, gated by that group's delayed live bit.
- R10: When `init` and `done` are 1 in the same cycle, `init` wins: the transform stays live and the run-on count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Transform start pulse; captures delay codes |
| done | input | 1 | End-of-transform pulse from the sequencer |
| runon_len | input | CNT_W | Number of clocks to stay live after `done` |
| dly_code | input | NGRP*3 | Per-group delay codes, 3 bits per group |
| grp_in | input | NGRP*GW | Raw output groups from the sequencer |
| src_addr_in | input | AW | Raw source address |
| coef_addr_in | input | AW | Raw coefficient address |
| grp_out | output | NGRP*GW | Delayed and gated output groups |
| grp_done_out | output | NGRP | Done flag delayed per group |
| src_addr_out | output | AW | Undelayed source address |
| coef_addr_out | output | AW | Undelayed coefficient address |
| pipe_act | output | 1 | Any part of the pipeline is live |

## Verification
The groups are driven with a data pattern that differs every cycle and between groups, so an output one cycle early or late, or taken from a neighbour group, shows as a wrong value. Delay settings mix the extremes 0 and 7 with middle values in each run, which separates a wrong tap from a correct one and a shared code from per-group codes. Run-on is tried with zero, short and long counts, with a restart inside the window and with `init` and `done` in the same cycle, which separates a gap-free restart, the exact tail length and the priority of start over end. A code change in mid-transform tells a latched code apart from one that follows the input.

// File: rtl/oda_pkg.sv
`timescale 1ns/1ps
package oda_pkg;
  localparam int MAX_DLY = 7;
  localparam int CODE_W  = $clog2(MAX_DLY + 1);
  typedef logic [CODE_W-1:0] dly_code_t;
endpackage

// File: rtl/oda_runon.sv
`timescale 1ns/1ps
module oda_runon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             done,
  input  logic [CNT_W-1:0] runon_len,
  output logic             live
);
  logic             running_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (init) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end else if (done) begin
      running_q <= 1'b0;
      cnt_q     <= runon_len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign live = running_q | (cnt_q != '0);

  // R4: count reloads on done
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !init) |=> (cnt_q == $past(runon_len) && !running_q));
  // R4: count steps down by one
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !done && !init) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R10: start beats end
  a_r10_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (running_q && cnt_q == '0));
endmodule

// File: rtl/oda_tap_line.sv
`timescale 1ns/1ps
module oda_tap_line
  import oda_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  dly_code_t     code_in,
  input  logic [GW-1:0] din,
  input  logic          live_in,
  input  logic          done_in,
  output logic [GW-1:0] dout,
  output logic          done_out,
  output logic          live_out
);
  localparam int SW = GW + 2;

  dly_code_t     code_q;
  logic          arm_q;
  logic [SW-1:0] stage [MAX_DLY];
  logic [SW-1:0] tapv  [MAX_DLY+1];
  logic [SW-1:0] sel;

  assign tapv[0] = {live_in, done_in, din};
  for (genvar k = 1; k <= MAX_DLY; k++) begin : g_tap
    assign tapv[k] = stage[k-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_DLY; k++) stage[k] <= '0;
      code_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      stage[0] <= tapv[0];
      for (int k = 1; k < MAX_DLY; k++) stage[k] <= stage[k-1];
      if (init) code_q <= code_in;
      arm_q <= 1'b1;
    end
  end

  assign sel      = tapv[code_q];
  assign live_out = sel[SW-1];
  assign done_out = sel[SW-1] & sel[SW-2];
  assign dout     = sel[SW-1] ? sel[GW-1:0] : '0;

  // R3: active code moves only on init
  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> $stable(code_q));
  // R2: one-clock setting follows the previous cycle
  a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && code_q == 3'd1) |->
      (live_out == $past(live_in) && dout == ($past(live_in) ? $past(din) : '0)));
endmodule

// File: rtl/pix_out_aligner.sv
`timescale 1ns/1ps
module pix_out_aligner
  import oda_pkg::*;
#(
  parameter int NGRP  = 3,
  parameter int GW    = 8,
  parameter int AW    = 12,
  parameter int CNT_W = 8,
  localparam int CODES_W = NGRP * CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               done,
  input  logic [CNT_W-1:0]   runon_len,
  input  logic [CODES_W-1:0] dly_code,
  input  logic [NGRP*GW-1:0] grp_in,
  input  logic [AW-1:0]      src_addr_in,
  input  logic [AW-1:0]      coef_addr_in,
  output logic [NGRP*GW-1:0] grp_out,
  output logic [NGRP-1:0]    grp_done_out,
  output logic [AW-1:0]      src_addr_out,
  output logic [AW-1:0]      coef_addr_out,
  output logic               pipe_act
);
  logic            live;
  logic [NGRP-1:0] tap_live;

  oda_runon #(.CNT_W(CNT_W)) u_runon (
    .clk(clk), .rst_n(rst_n), .init(init), .done(done),
    .runon_len(runon_len), .live(live)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    oda_tap_line #(.GW(GW)) u_line (
      .clk(clk), .rst_n(rst_n), .init(init),
      .code_in(dly_code[g*CODE_W +: CODE_W]),
      .din(grp_in[g*GW +: GW]),
      .live_in(live), .done_in(done),
      .dout(grp_out[g*GW +: GW]),
      .done_out(grp_done_out[g]),
      .live_out(tap_live[g])
    );
  end

  assign src_addr_out  = src_addr_in;
  assign coef_addr_out = coef_addr_in;
  assign pipe_act      = live | (|tap_live);

  // R5: nothing leaves while the whole pipeline is idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_act |-> (grp_out == '0 && grp_done_out == '0));
  // R7: a live start always shows on the activity flag next cycle
  a_r7_start_active: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> pipe_act);
endmodule

// File: tb/sim_pix_out_aligner.sv
`timescale 1ns/1ps
module sim_pix_out_aligner;
  localparam int NG = 3, GW = 8, AW = 12, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, done = 1'b0;
  logic [CW-1:0]   runon_len = '0;
  logic [NG*3-1:0] dly_code = '0;
  logic [NG*GW-1:0] grp_in = '0, grp_out;
  logic [NG-1:0]   grp_done_out;
  logic [AW-1:0]   src_addr_in = '0, coef_addr_in = '0, src_addr_out, coef_addr_out;
  logic            pipe_act;

  int checks = 0, errors = 0, cyc = 0;

  // bench model state
  logic          m_run = 1'b0;
  int            m_cnt = 0;
  int            m_code [NG];
  logic [GW+1:0] hist [NG][8];
  logic [GW+1:0] cur_s [NG];

  always #4 clk = ~clk;

  pix_out_aligner #(.NGRP(NG), .GW(GW), .AW(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .done(done), .runon_len(runon_len),
    .dly_code(dly_code), .grp_in(grp_in), .src_addr_in(src_addr_in),
    .coef_addr_in(coef_addr_in), .grp_out(grp_out), .grp_done_out(grp_done_out),
    .src_addr_out(src_addr_out), .coef_addr_out(coef_addr_out), .pipe_act(pipe_act)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_clear();
    m_run = 1'b0; m_cnt = 0;
    for (int g = 0; g < NG; g++) begin
      m_code[g] = 0;
      for (int k = 0; k < 8; k++) hist[g][k] = '0;
    end
  endtask

  // one clock: drive at negedge, sample mid-cycle, advance the model at the edge
  task automatic step(string tag, logic i_v, logic d_v);
    logic mlive, any;
    logic [GW+1:0] e;
    init = i_v; done = d_v;
    for (int g = 0; g < NG; g++) grp_in[g*GW +: GW] = 8'(cyc * 7 + g * 37 + 5);
    src_addr_in = 12'(cyc * 13 + 1); coef_addr_in = 12'(cyc * 29 + 3);
    #2;
    mlive = m_run | (m_cnt != 0);
    any = 1'b0;
    for (int g = 0; g < NG; g++) begin
      cur_s[g] = {mlive, d_v, grp_in[g*GW +: GW]};
      e = (m_code[g] == 0) ? cur_s[g] : hist[g][m_code[g]-1];
      any |= e[GW+1];
      chk(tag, int'(grp_out[g*GW +: GW]), e[GW+1] ? int'(e[GW-1:0]) : 0);
      chk("R9 delayed done", int'(grp_done_out[g]), int'(e[GW+1] & e[GW]));
    end
    chk("R7 pipe_act", int'(pipe_act), int'(mlive | any));
    chk("R1 src addr", int'(src_addr_out), int'(src_addr_in));
    chk("R1 coef addr", int'(coef_addr_out), int'(coef_addr_in));
    @(posedge clk);
    for (int g = 0; g < NG; g++) begin
      for (int k = 7; k > 0; k--) hist[g][k] = hist[g][k-1];
      hist[g][0] = cur_s[g];
    end
    if (i_v) begin
      m_run = 1'b1; m_cnt = 0;
      for (int g = 0; g < NG; g++) m_code[g] = int'(dly_code[g*3 +: 3]);
    end else if (d_v) begin
      m_run = 1'b0; m_cnt = int'(runon_len);
    end else if (m_cnt != 0) m_cnt--;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; init = 1'b1; done = 1'b1; grp_in = '1; dly_code = '1;
    src_addr_in = 12'h5a5; coef_addr_in = 12'h3c3;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 reset grp_out", int'(grp_out), 0);
    chk("R8 reset done_out", int'(grp_done_out), 0);
    chk("R8 reset pipe_act", int'(pipe_act), 0);
    chk("R1 src addr in reset", int'(src_addr_out), 12'h5a5);
    chk("R1 coef addr in reset", int'(coef_addr_out), 12'h3c3);
    @(negedge clk);
    init = 1'b0; done = 1'b0; dly_code = '0; rst_n = 1'b1;
    model_clear();
    idle("R8 after reset", 3);
  endtask

  task automatic t_delays();
    dly_code = {3'd7, 3'd3, 3'd0}; runon_len = 8'd10;
    step("R2 R4 start", 1'b1, 1'b0);
    idle("R2 R4 body", 14);
    step("R2 R4 done", 1'b0, 1'b1);
    idle("R4 R5 tail", 22);
  endtask

  task automatic t_runon0();
    dly_code = {3'd1, 3'd5, 3'd2}; runon_len = 8'd0;
    step("R5 start", 1'b1, 1'b0);
    idle("R5 body", 6);
    step("R5 done", 1'b0, 1'b1);
    idle("R5 zero run-on tail", 12);
  endtask

  task automatic t_code_hold();
    dly_code = {3'd2, 3'd4, 3'd6}; runon_len = 8'd7;
    step("R3 start", 1'b1, 1'b0);
    idle("R3 body", 3);
    dly_code = {3'd0, 3'd7, 3'd1};
    idle("R3 code changed mid-run", 8);
    step("R3 done", 1'b0, 1'b1);
    idle("R3 tail", 18);
  endtask

  task automatic t_back2back();
    dly_code = {3'd6, 3'd2, 3'd4}; runon_len = 8'd8;
    step("R6 start", 1'b1, 1'b0);
    idle("R6 first", 6);
    step("R6 done", 1'b0, 1'b1);
    idle("R6 run-on", 2);
    step("R6 restart", 1'b1, 1'b0);
    idle("R6 second", 6);
    step("R6 done2", 1'b0, 1'b1);
    idle("R6 tail", 20);
  endtask

  task automatic t_same();
    dly_code = {3'd3, 3'd0, 3'd5}; runon_len = 8'd3;
    step("R10 start", 1'b1, 1'b0);
    idle("R10 body", 3);
    step("R10 init+done", 1'b1, 1'b1);
    idle("R10 still live", 4);
    step("R10 done", 1'b0, 1'b1);
    idle("R10 tail", 14);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog (all) actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    t_reset();
    t_delays();
    t_runon0();
    t_code_hold();
    t_back2back();
    t_same();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule